// File: doc/BRIEF.md
# Reliability-Marked Flip Assistant

This block sits around an algebraic hard-decision component decoder in a windowed, iteratively decoded product-like code. The decoder itself is not touched. Each component word holds bits from two blocks. The lower half of the word lies in the previous block, where each bit is also covered by a crossing codeword. The upper half lies in the newest block. The assistant takes a 4-bit channel reliability for every bit of the word. It marks strongly trusted bits and picks out the weakest bits of the newest half. It then uses these marks in two ways: to reject decoder proposals that look like miscorrections, and to prepare one retry by pre-flipping weak bits.

A caller presents a word, its reliabilities and one "crossing word already clean" flag per previous-half bit, using a one-cycle `start`. The assistant issues the word to the decoder with `dec_req` and waits for `dec_done`. It then either accepts the corrected word, or builds a modified word and requests one redecode, or gives up and returns the original word marked as rejected. The result appears as a one-cycle `out_valid` pulse together with `out_word` and `out_accept`.

Top module: `relflip_assist`

## Requirements
- R1: A bit whose 4-bit reliability is 12 or more is marked trusted in `hrb_mask`. This applies to every bit position. Bit i uses reliability bits `rel_in[4i+3:4i]`.
- R2: `hub_mask` marks at most 3 weak bits. They are chosen only from the untrusted bits of the newest half (bits 8..15), taking the smallest reliabilities first. Equal reliabilities are ranked lower index first.
- R3: A decoder proposal is a miscorrection if it flips a previous-half bit i (0..7) whose flag `xz_in[i]` is 1. A flip on a bit whose flag is 0 does not count.
- R4: A decoder proposal is a miscorrection if it flips any trusted bit of the newest half. An accepted result never differs from the original word on such a bit.
- R5: After a first-attempt failure, the redecode word is the original word with its lowest-ranked weak bit inverted. At most one redecode is made per word.
- R6: After a first-attempt miscorrection with f proposed flips, the redecode word is the original word with its k lowest-ranked weak bits inverted, where k = 3 − f (t = 2).
- R7: A successful, non-vetoed decode is accepted. `out_word` is the word sent to the decoder XOR `dec_flips`, and `out_accept` is 1.
- R8: A failure or miscorrection on the redecode returns the original word with `out_accept` = 0.
- R9: If the word has no weak bits, a failure or miscorrection is rejected at once, with no redecode request.
- R10: After reset, `dec_req` and `out_valid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that loads a new word |
| word_in | input | 16 | Hard-decision codeword bits |
| rel_in | input | 64 | 4-bit reliability per bit, bit i at [4i+3:4i] |
| xz_in | input | 8 | Crossing-word-clean flag per previous-half bit |
| dec_req | output | 1 | Request to the component decoder |
| dec_word | output | 16 | Word handed to the decoder |
| dec_done | input | 1 | Decoder result valid |
| dec_fail | input | 1 | Decoder found no codeword in range |
| dec_flips | input | 16 | Positions the decoder proposes to flip |
| hrb_mask | output | 16 | Trusted-bit marks of the loaded word |
| hub_mask | output | 16 | Weak-bit marks of the loaded word |
| out_valid | output | 1 | One-cycle result pulse |
| out_word | output | 16 | Final word |
| out_accept | output | 1 | 1 if the word was accepted, 0 if rejected |

## Verification
The assertions assume that the decoder answers each request exactly once. They also assume that it never proposes more than t = 2 flips, because a bounded-distance decoder of radius 2 cannot do so. Under these assumptions a miscorrection retry always inverts at least one weak bit. The bench plays the decoder: it replies to each `dec_req` once, holds `dec_done` for a single cycle and keeps every flip mask to at most two bits. A new `start` is raised only after the previous result has been seen.

// File: rtl/relflip_pkg.sv
package relflip_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } rf_state_e;

  // True when bit a is less reliable than bit b (lower index wins ties).
  function automatic logic ranks_before(input int rel_a, input int idx_a,
                                        input int rel_b, input int idx_b);
    return (rel_a < rel_b) || ((rel_a == rel_b) && (idx_a < idx_b));
  endfunction

  // Number of weak bits to pre-flip after a miscorrection: t+1-flips, held in [0, cap].
  function automatic int retry_width(input int t, input int nflips, input int cap);
    int k;
    k = t + 1 - nflips;
    if (k < 0) k = 0;
    if (k > cap) k = cap;
    return k;
  endfunction

endpackage

// File: rtl/relflip_marker.sv
module relflip_marker
  import relflip_pkg::*;
#(
  parameter int N     = 16,
  parameter int RW    = 4,
  parameter int D0    = 3,
  parameter int DELTA = 12,
  parameter int KW    = 5
) (
  input  logic [N*RW-1:0] rel,
  input  logic [KW-1:0]   pick_k,
  output logic [N-1:0]    hrb,
  output logic [N-1:0]    hub,
  output logic [N-1:0]    pick
);
  localparam int H = N / 2;
  localparam logic [RW-1:0] DELTA_V = RW'(DELTA);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      hrb[i] = (rel[i*RW +: RW] >= DELTA_V);
    end
    for (int i = 0; i < N; i++) begin
      int cnt;
      cnt     = 0;
      hub[i]  = 1'b0;
      pick[i] = 1'b0;
      if (i >= H && !hrb[i]) begin
        for (int j = H; j < N; j++) begin
          if (j != i && !hrb[j] &&
              ranks_before(int'(rel[j*RW +: RW]), j, int'(rel[i*RW +: RW]), i))
            cnt++;
        end
        hub[i]  = (cnt < D0);
        pick[i] = (cnt < int'(pick_k)) && (cnt < D0);
      end
    end
  end

endmodule

// File: rtl/relflip_veto.sv
module relflip_veto #(
  parameter int N  = 16,
  parameter int KW = 5
) (
  input  logic [N-1:0]   flips,
  input  logic [N-1:0]   hrb,
  input  logic [N/2-1:0] xz,
  output logic           cross_hit,
  output logic           hrb_hit,
  output logic           miscorr,
  output logic [KW-1:0]  nflips
);
  localparam int H = N / 2;

  assign cross_hit = |(flips[H-1:0] & xz);
  assign hrb_hit   = |(flips[N-1:H] & hrb[N-1:H]);
  assign miscorr   = cross_hit | hrb_hit;
  assign nflips    = KW'($countones(flips));

endmodule

// File: rtl/relflip_assist.sv
module relflip_assist
  import relflip_pkg::*;
#(
  parameter int N     = 16,
  parameter int RW    = 4,
  parameter int T     = 2,
  parameter int D0    = 3,
  parameter int DELTA = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [N-1:0]      word_in,
  input  logic [N*RW-1:0]   rel_in,
  input  logic [N/2-1:0]    xz_in,
  output logic              dec_req,
  output logic [N-1:0]      dec_word,
  input  logic              dec_done,
  input  logic              dec_fail,
  input  logic [N-1:0]      dec_flips,
  output logic [N-1:0]      hrb_mask,
  output logic [N-1:0]      hub_mask,
  output logic              out_valid,
  output logic [N-1:0]      out_word,
  output logic              out_accept
);
  localparam int H  = N / 2;
  localparam int KW = $clog2(N + 1);

  rf_state_e         state_q;
  logic [N-1:0]      orig_q, cur_q;
  logic [N*RW-1:0]   rel_q;
  logic [H-1:0]      xz_q;
  logic              retry_q;
  logic              valid_q, accept_q;
  logic [N-1:0]      oword_q;

  logic [N-1:0]      pick_mask;
  logic [KW-1:0]     pick_k;
  logic              cross_hit, hrb_hit, miscorr;
  logic [KW-1:0]     nflips;

  // Named events for the assertions.
  logic              evt_result, fin_ok, give_up, take_retry;

  relflip_marker #(.N(N), .RW(RW), .D0(D0), .DELTA(DELTA), .KW(KW)) u_marker (
    .rel    (rel_q),
    .pick_k (pick_k),
    .hrb    (hrb_mask),
    .hub    (hub_mask),
    .pick   (pick_mask)
  );

  relflip_veto #(.N(N), .KW(KW)) u_veto (
    .flips     (dec_flips),
    .hrb       (hrb_mask),
    .xz        (xz_q),
    .cross_hit (cross_hit),
    .hrb_hit   (hrb_hit),
    .miscorr   (miscorr),
    .nflips    (nflips)
  );

  always_comb begin
    if (dec_fail) pick_k = KW'(1);
    else          pick_k = KW'(retry_width(T, int'(nflips), D0));
  end

  assign evt_result = (state_q == ST_WAIT) && dec_done;
  assign fin_ok     = evt_result && !dec_fail && !miscorr;
  assign give_up    = evt_result && !fin_ok && (retry_q || (hub_mask == '0));
  assign take_retry = evt_result && !fin_ok && !give_up;

  assign dec_req    = (state_q == ST_REQ);
  assign dec_word   = cur_q;
  assign out_valid  = valid_q;
  assign out_word   = oword_q;
  assign out_accept = accept_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      orig_q   <= '0;
      cur_q    <= '0;
      rel_q    <= '0;
      xz_q     <= '0;
      retry_q  <= 1'b0;
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
      oword_q  <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          orig_q  <= word_in;
          cur_q   <= word_in;
          rel_q   <= rel_in;
          xz_q    <= xz_in;
          retry_q <= 1'b0;
          state_q <= ST_REQ;
        end
        ST_REQ: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (fin_ok) begin
            oword_q  <= cur_q ^ dec_flips;
            accept_q <= 1'b1;
            valid_q  <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (give_up) begin
            oword_q  <= orig_q;
            accept_q <= 1'b0;
            valid_q  <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (take_retry) begin
            cur_q   <= orig_q ^ pick_mask;
            retry_q <= 1'b1;
            state_q <= ST_REQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: weak marks stay within the limit and never sit on trusted bits.
  a_r2_hub_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hub_mask) <= D0);
  a_r2_hub_not_hrb: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_mask & hrb_mask) == '0);
  // R4: an accepted word leaves every trusted newest-half bit as received.
  a_r4_accept_spares_hrb: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && accept_q) |-> ((oword_q ^ orig_q) & {hrb_mask[N-1:H], {H{1'b0}}}) == '0);
  // R5: a result on the redecode always ends the word.
  a_r5_single_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_result && retry_q) |=> (state_q == ST_IDLE) && valid_q);
  // R6: a redecode word differs from the original (decoder proposes at most T flips).
  a_r6_retry_differs: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && retry_q) |-> (dec_word != orig_q));
  // R8: a rejected result carries the original word.
  a_r8_reject_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !accept_q) |-> (oword_q == orig_q));

endmodule

// File: tb/relflip_assist_tb.sv
module relflip_assist_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] word_in = '0;
  logic [63:0] rel_in = '0;
  logic [7:0]  xz_in = '0;
  logic        dec_req;
  logic [15:0] dec_word;
  logic        dec_done = 1'b0;
  logic        dec_fail = 1'b0;
  logic [15:0] dec_flips = '0;
  logic [15:0] hrb_mask, hub_mask;
  logic        out_valid;
  logic [15:0] out_word;
  logic        out_accept;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [63:0] REL_RAMP = 64'hFEDC_BA98_7654_3210;

  always #(CLK_PERIOD/2) clk = ~clk;

  relflip_assist u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(word_in), .rel_in(rel_in),
    .xz_in(xz_in), .dec_req(dec_req), .dec_word(dec_word), .dec_done(dec_done),
    .dec_fail(dec_fail), .dec_flips(dec_flips), .hrb_mask(hrb_mask),
    .hub_mask(hub_mask), .out_valid(out_valid), .out_word(out_word),
    .out_accept(out_accept)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference marks: trusted by threshold, weak by repeated minimum search.
  function automatic logic [15:0] ref_hrb(input logic [63:0] r);
    logic [15:0] m = '0;
    for (int i = 0; i < 16; i++) m[i] = (r[i*4 +: 4] > 4'd11);
    return m;
  endfunction

  function automatic logic [15:0] ref_weak(input logic [63:0] r, input int k);
    logic [15:0] taken = '0;
    logic [15:0] h = ref_hrb(r);
    for (int p = 0; p < k; p++) begin
      int best = -1;
      for (int i = 8; i < 16; i++) begin
        if (!h[i] && !taken[i]) begin
          if (best < 0) best = i;
          else if (r[i*4 +: 4] < r[best*4 +: 4]) best = i;
        end
      end
      if (best >= 0) taken[best] = 1'b1;
    end
    return taken;
  endfunction

  task automatic load(input logic [15:0] w, input logic [63:0] r, input logic [7:0] x);
    @(negedge clk);
    word_in = w; rel_in = r; xz_in = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Waits for the next request or result; got_req tells which.
  task automatic await(output logic got_req);
    got_req = 1'b0;
    for (int c = 0; c < 20; c++) begin
      if (dec_req || out_valid) break;
      @(negedge clk);
    end
    got_req = dec_req;
  endtask

  task automatic reply(input logic fail, input logic [15:0] flips);
    @(negedge clk);
    dec_done = 1'b1; dec_fail = fail; dec_flips = flips;
    @(negedge clk);
    dec_done = 1'b0; dec_fail = 1'b0; dec_flips = '0;
  endtask

  task automatic test_reset();
    chk("R10 dec_req after reset", {15'b0, dec_req}, 16'h0);
    chk("R10 out_valid after reset", {15'b0, out_valid}, 16'h0);
  endtask

  task automatic test_clean_accept();
    logic g;
    load(16'hA5C3, REL_RAMP, 8'h00);
    await(g);
    chk("R1 hrb marks", hrb_mask, ref_hrb(REL_RAMP));
    chk("R2 hub marks", hub_mask, ref_weak(REL_RAMP, 3));
    chk("R7 first word", dec_word, 16'hA5C3);
    reply(1'b0, 16'h0101);
    await(g);
    chk("R7 result pulse", {15'b0, out_valid}, 16'h1);
    chk("R7 accepted word", out_word, 16'hA5C3 ^ 16'h0101);
    chk("R7 accept flag", {15'b0, out_accept}, 16'h1);
  endtask

  task automatic test_fail_retry();
    logic g;
    logic [15:0] w = 16'h3C5A;
    logic [15:0] rw = w ^ ref_weak(REL_RAMP, 1);
    load(w, REL_RAMP, 8'h00);
    await(g);
    reply(1'b1, 16'h0000);
    await(g);
    chk("R5 redecode requested", {15'b0, g}, 16'h1);
    chk("R5 one weak bit flipped", dec_word, rw);
    reply(1'b0, 16'h0002);
    await(g);
    chk("R7 accepted after retry", out_word, rw ^ 16'h0002);
    chk("R7 accept after retry", {15'b0, out_accept}, 16'h1);
  endtask

  task automatic test_hrb_veto();
    logic g;
    logic [15:0] w = 16'h0F0F;
    load(w, REL_RAMP, 8'h00);
    await(g);
    reply(1'b0, 16'h2000);
    await(g);
    chk("R4 trusted-bit flip vetoed", {15'b0, g}, 16'h1);
    chk("R6 two weak bits for one flip", dec_word, w ^ ref_weak(REL_RAMP, 2));
    reply(1'b0, 16'h0000);
    await(g);
    chk("R4 accepted word spares trusted bit", out_word, w ^ ref_weak(REL_RAMP, 2));
  endtask

  task automatic test_cross_veto_reject();
    logic g;
    logic [15:0] w = 16'h1234;
    load(w, REL_RAMP, 8'h08);
    await(g);
    reply(1'b0, 16'h0408);
    await(g);
    chk("R3 clean crossing word vetoed", {15'b0, g}, 16'h1);
    chk("R6 one weak bit for two flips", dec_word, w ^ ref_weak(REL_RAMP, 1));
    reply(1'b0, 16'h0408);
    await(g);
    chk("R8 second veto rejects", {15'b0, out_accept}, 16'h0);
    chk("R8 original restored", out_word, w);
  endtask

  task automatic test_cross_allowed();
    logic g;
    logic [15:0] w = 16'hBEEF;
    load(w, REL_RAMP, 8'hF7);
    await(g);
    reply(1'b0, 16'h0008);
    await(g);
    chk("R3 unflagged crossing flip no retry", {15'b0, g}, 16'h0);
    chk("R3 unflagged crossing flip accepted", out_word, w ^ 16'h0008);
  endtask

  task automatic test_tie_break();
    logic g;
    logic [63:0] r = 64'h1555_5555_5555_5555;
    logic [15:0] w = 16'h7777;
    load(w, r, 8'h00);
    await(g);
    chk("R2 tie break lower index", hub_mask, 16'h8300);
    reply(1'b1, 16'h0000);
    await(g);
    chk("R5 weakest bit flipped", dec_word, w ^ 16'h8000);
    reply(1'b1, 16'h0000);
    await(g);
    chk("R8 second failure rejects", {15'b0, out_accept}, 16'h0);
    chk("R8 original after failure", out_word, w);
  endtask

  task automatic test_no_hub();
    logic g;
    logic [63:0] r = 64'hCCCC_CCCC_0000_0000;
    logic [15:0] w = 16'h55AA;
    load(w, r, 8'h00);
    await(g);
    chk("R1 all newest bits trusted", hrb_mask, 16'hFF00);
    chk("R9 no weak bits", hub_mask, 16'h0000);
    reply(1'b1, 16'h0000);
    await(g);
    chk("R9 no redecode", {15'b0, g}, 16'h0);
    chk("R9 immediate reject", {14'b0, out_valid, out_accept}, 16'h2);
    chk("R9 original word", out_word, w);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_clean_accept();
    test_fail_retry();
    test_hrb_veto();
    test_cross_veto_reject();
    test_cross_allowed();
    test_tie_break();
    test_no_hub();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule